// File: doc/BRIEF.md
# Clause-22 Management Frame Master

This block drives the two-wire station management bus that a MAC uses to read and write PHY registers. A host loads one 32-bit command word. The word is laid out exactly as the serial frame that follows the preamble: start code, opcode, PHY address, register address, turnaround and 16 data bits. After that single write the block generates the management clock, sends a full preamble of ones, and shifts the command word out MSB first. On a read it releases the data line from the turnaround onward and collects the PHY's reply on rising clock edges.

Timing comes from a speed register. The register holds a clock divider and an output hold count. The management clock toggles every `divider` system cycles, so the host picks the divider as the system clock rate divided by 5 MHz, rounded up. Each new bit appears on the data line a fixed number of system cycles after the falling clock edge. A busy flag covers the whole frame, and a sticky completion flag is raised when the frame ends. Software clears that flag by writing a one to it.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc, mdio_oe, busy and evt are 0 and rd_data is 0.
- R2: A write to address 0 starts a frame only while busy is 0. busy rises on the accepting edge and stays high until the frame ends. A write to address 0 while busy is 1 has no effect on the frame in progress and does not start a second one.
- R3: A frame is 64 bits, each launched while mdc is low and valid at the rising mdc edge. It is 32 ones followed by command bits 31 down to 0. Bits 29:28 equal to 2'b10 mark a read; any other value marks a write.
- R4: On a read, mdio_oe is 0 from frame bit 46 (the first turnaround bit) to the end of the frame. mdio_i is sampled at the rising mdc edges of frame bits 48 to 63, MSB first, and the 16 sampled bits appear on rd_data after the frame.
- R5: On a write, mdio_oe is 1 for all 64 bits, and rd_data holds command bits 15:0 after the frame.
- R6: The divider is speed-register bits 6:1. Each mdc half period lasts D system cycles, where D is the divider value, or 2 when the divider is below 2. A frame keeps busy high for 128*D cycles, and mdc is 0 whenever busy is 0.
- R7: The hold count is speed-register bits 10:8. mdio_o and mdio_oe change exactly hold+1 cycles after the accepting edge or an mdc falling edge. Valid settings keep hold at most D-2.
- R8: evt is set on the edge that ends a frame. It stays set until a write to address 1 with bit 0 equal to 1. Such a write with bit 0 equal to 0 has no effect. When a frame ends in the same cycle as a clearing write, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 event, 2 speed |
| wr_data | input | 32 | Register write data |
| mdio_i | input | 1 | Sensed level of the management data line |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven onto the line |
| mdio_oe | output | 1 | Drive enable for the data line |
| busy | output | 1 | Frame in progress |
| evt | output | 1 | Sticky frame-complete flag |
| rd_data | output | 16 | Data returned by the last frame |

## Verification
Two functions can fall in the same cycle: the completion logic setting the event flag, and a software write clearing it. The bench derives the completion edge arithmetically as 128 times the effective divider after the accepting edge. It then places a clearing write on exactly that edge. The outcome is judged at the ports: evt must read 1 afterwards and busy must already be 0. A later ordinary clearing write must then bring evt to 0.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_LEN   = 32;
    localparam int CMD_W     = 32;
    localparam int DATA_W    = 16;
    localparam int FRAME_LEN = PRE_LEN + CMD_W;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam int BIT_W     = $clog2(CMD_W);
    // first turnaround bit and first data bit, counted from frame start
    localparam int TA_POS    = PRE_LEN + CMD_W - DATA_W - 2;
    localparam int RD_POS    = PRE_LEN + CMD_W - DATA_W;
    localparam int OP_LSB    = 28;
    localparam logic [1:0] OP_READ = 2'b10;

    localparam logic [1:0] RA_CMD = 2'd0;
    localparam logic [1:0] RA_EVT = 2'd1;
    localparam logic [1:0] RA_SPD = 2'd2;
    localparam int DIV_LSB  = 1;
    localparam int HOLD_LSB = 8;
    localparam int EVT_BIT  = 0;

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [CMD_W-1:0]  word;
        logic              dout;
        logic              oe;
        logic [DATA_W-1:0] data;
    } frame_st;

endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              run,
    input  logic [DIV_W-1:0]  div,
    input  logic [HOLD_W-1:0] hold,
    output logic              mdc,
    output logic              drive_stb,
    output logic              rise_stb,
    output logic              fall_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] pcnt;
        logic             hb;
    } tick_st;

    tick_st q, d;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] hold_ext;

    always_comb begin
        last      = ((div < DIV_W'(2)) ? DIV_W'(2) : div) - DIV_W'(1);
        hold_ext  = DIV_W'(hold);
        drive_stb = run && !q.hb && (q.pcnt == hold_ext);
        rise_stb  = run && !q.hb && (q.pcnt == last);
        fall_stb  = run &&  q.hb && (q.pcnt == last);
        d = q;
        if (start) begin
            d.pcnt = '0;
            d.hb   = 1'b0;
        end else if (run) begin
            if (q.pcnt == last) begin
                d.pcnt = '0;
                d.hb   = !q.hb;
            end else begin
                d.pcnt = q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc = q.hb;

    // R6: a rising management clock is always the end of a full low half
    a_r6_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $past(rise_stb));

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              drive_stb,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              dout,
    output logic              oe,
    output logic [DATA_W-1:0] data
);

    frame_st q, d;
    logic             is_read;
    logic [BIT_W-1:0] sel;

    always_comb begin
        is_read = (q.word[OP_LSB +: 2] == OP_READ);
        sel     = BIT_W'(CMD_W - 1) - q.idx[BIT_W-1:0];
        done    = 1'b0;
        d = q;
        if (start) begin
            d.busy = 1'b1;
            d.idx  = '0;
            d.word = cmd;
            d.data = cmd[DATA_W-1:0];
        end else if (q.busy) begin
            if (drive_stb) begin
                d.dout = (q.idx < IDX_W'(PRE_LEN)) ? 1'b1 : q.word[sel];
                d.oe   = !(is_read && (q.idx >= IDX_W'(TA_POS)));
            end
            if (rise_stb && is_read && (q.idx >= IDX_W'(RD_POS)))
                d.data = {q.data[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
                if (q.idx == IDX_W'(FRAME_LEN - 1)) begin
                    d.busy = 1'b0;
                    d.oe   = 1'b0;
                    done   = 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.dout <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;
    assign dout = q.dout;
    assign oe   = q.oe;
    assign data = q.data;

    // R2: the register front end never launches into a running frame
    a_r2_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);
    // R4: line released while the PHY returns data
    a_r4_released_data: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && is_read && q.idx >= IDX_W'(RD_POS)) |-> !q.oe);
    // R5: write frames keep driving once the first bit is out
    a_r5_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !is_read && q.idx != '0) |-> q.oe);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int HOLD_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              mdio_i,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              busy,
    output logic              evt,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [HOLD_W-1:0] hold;
        logic              evt;
    } ctl_st;

    ctl_st q, d;
    logic accept, clr, done;
    logic drive_stb, rise_stb, fall_stb;
    logic spare_unused;

    assign spare_unused = ^wr_data;

    always_comb begin
        accept = wr_en && (wr_addr == RA_CMD) && !busy;
        clr    = wr_en && (wr_addr == RA_EVT) && wr_data[EVT_BIT];
        d = q;
        if (wr_en && (wr_addr == RA_SPD)) begin
            d.div  = wr_data[DIV_LSB +: DIV_W];
            d.hold = wr_data[HOLD_LSB +: HOLD_W];
        end
        if (done)     d.evt = 1'b1;
        else if (clr) d.evt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    mdio_tick #(.DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .run       (busy),
        .div       (q.div),
        .hold      (q.hold),
        .mdc       (mdc),
        .drive_stb (drive_stb),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb)
    );

    mdio_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .cmd       (wr_data),
        .drive_stb (drive_stb),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .done      (done),
        .dout      (mdio_o),
        .oe        (mdio_oe),
        .data      (rd_data)
    );

    assign evt = q.evt;

    // R6: clock parked low outside a frame
    a_r6_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);
    // R8: frame end raises the flag, even against a clearing write
    a_r8_evt_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> evt);
    // R8: flag is sticky without a clearing write
    a_r8_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr) |=> evt);

endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe, busy, evt;
    logic [15:0] rd_data;

    int total = 0;
    int fails = 0;

    // monitor state
    int          cur_div = 2;
    int          cur_hold = 0;
    logic [15:0] phy_val = 16'h0;
    int          nbits = 0;
    int          run_len = 0;
    int          since_fall = 0;
    int          busy_cycles = 0;
    int          bad_half = 0;
    int          bad_hold = 0;
    logic [63:0] rec_o = '0;
    logic [63:0] rec_oe = '0;
    logic        p_mdc = 1'b0, p_busy = 1'b0, p_o = 1'b1, p_oe = 1'b0;

    always #4 clk = !clk;

    mdio_master u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mdio_i(mdio_i), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .busy(busy), .evt(evt), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // observe the bus between edges; also acts as the PHY responder
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !p_busy) begin
                nbits = 0; run_len = 1; since_fall = 0; busy_cycles = 1;
                bad_half = 0; bad_hold = 0;
            end else if (busy) begin
                busy_cycles++;
                since_fall++;
                if (mdc != p_mdc) begin
                    if (run_len != cur_div) bad_half++;
                    run_len = 1;
                    if (!mdc) since_fall = 0;
                    else begin
                        if (nbits < 64) begin
                            rec_o[nbits]  = mdio_o;
                            rec_oe[nbits] = mdio_oe;
                        end
                        nbits++;
                    end
                end else begin
                    run_len++;
                end
                if ((mdio_o != p_o || mdio_oe != p_oe) && since_fall != cur_hold + 1)
                    bad_hold++;
            end else if (p_busy) begin
                if (run_len != cur_div) bad_half++;
            end
            mdio_i = (nbits >= 48 && nbits < 64) ? phy_val[63 - nbits] : 1'b1;
            p_mdc = mdc; p_busy = busy; p_o = mdio_o; p_oe = mdio_oe;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'd0;
    endtask

    task automatic set_speed(input int dv, input int h);
        wr(2'd2, (32'(h) << 8) | (32'(dv) << 1));
        cur_div  = (dv < 2) ? 2 : dv;
        cur_hold = h;
    endtask

    task automatic run_frame(input logic [31:0] cmd, input logic [15:0] pv, input bit interrupt);
        bit          rd;
        logic [15:0] exp_rd;
        int          bad_bits;
        int          bad_oe;
        rd = (cmd[29:28] == 2'b10);
        phy_val = pv;
        wr(2'd0, cmd);
        check(busy == 1'b1, "R2 busy after accept", busy, 1);
        if (interrupt) begin
            repeat (100) @(negedge clk);
            wr(2'd0, ~cmd);
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        bad_bits = 0; bad_oe = 0;
        for (int i = 0; i < 64; i++) begin
            logic eb, eoe;
            eb  = (i < 32) ? 1'b1 : cmd[63 - i];
            eoe = !(rd && i >= 46);
            if (rec_oe[i] != eoe) bad_oe++;
            if (eoe && rec_o[i] != eb) bad_bits++;
        end
        check(nbits == 64, "R3 bit count", nbits, 64);
        check(bad_bits == 0, "R3 frame bits", bad_bits, 0);
        if (rd) check(bad_oe == 0, "R4 release pattern", bad_oe, 0);
        else    check(bad_oe == 0, "R5 drive pattern", bad_oe, 0);
        check(busy_cycles == 128 * cur_div, "R6 frame length", busy_cycles, 128 * cur_div);
        check(bad_half == 0, "R6 half period", bad_half, 0);
        check(bad_hold == 0, "R7 hold time", bad_hold, 0);
        exp_rd = rd ? pv : cmd[15:0];
        if (rd) check(rd_data == exp_rd, "R4 read data", rd_data, exp_rd);
        else    check(rd_data == exp_rd, "R5 write echo", rd_data, exp_rd);
        check(evt == 1'b1, "R8 event set", evt, 1);
        check(!mdc && !mdio_oe, "R6 idle after frame", {mdc, mdio_oe}, 0);
        wr(2'd1, 32'h1);
        @(negedge clk);
        check(evt == 1'b0, "R8 event cleared", evt, 0);
    endtask

    function automatic logic [31:0] mk_cmd(input bit rd, input int pa, input int ra, input logic [15:0] v);
        return {2'b01, rd ? 2'b10 : 2'b01, 5'(pa), 5'(ra), 2'b10, v};
    endfunction

    initial begin
        #(8 * 190000);
        total++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!mdc && !mdio_oe && !busy && !evt && rd_data == 16'h0,
              "R1 reset state", {mdc, mdio_oe, busy, evt, rd_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!mdc && !busy, "R1 idle after release", {mdc, busy}, 0);

        // sweep of divider and hold settings, one write and one read each
        for (int dv = 0; dv <= 9; dv++) begin
            int deff;
            if (dv == 5 || dv == 7 || dv == 8) continue;
            deff = (dv < 2) ? 2 : dv;
            for (int h = 0; h <= 7; h++) begin
                if (h > deff - 2) continue;
                if (dv == 9 && !(h == 0 || h == 3 || h == 7)) continue;
                set_speed(dv, h);
                run_frame(mk_cmd(1'b0, dv, h + 3, 16'hA5C3 ^ 16'(dv * 37 + h)), 16'h0, 1'b0);
                run_frame(mk_cmd(1'b1, 31 - dv, h, 16'h1234), 16'h3C96 ^ 16'(dv * 131 + h * 7), 1'b0);
            end
        end

        // data extremes
        set_speed(2, 0);
        run_frame(mk_cmd(1'b1, 5, 1, 16'hFFFF), 16'h0000, 1'b0);
        run_frame(mk_cmd(1'b1, 0, 31, 16'h0000), 16'hFFFF, 1'b0);
        run_frame(mk_cmd(1'b0, 31, 0, 16'h8001), 16'h0, 1'b0);

        // R2: command written mid-frame is ignored
        set_speed(4, 1);
        run_frame(mk_cmd(1'b0, 9, 17, 16'h5AA5), 16'h0, 1'b1);
        repeat (20) @(negedge clk);
        check(!busy, "R2 no second frame", busy, 0);

        // R8: clearing write with bit 0 low leaves the flag alone
        set_speed(3, 0);
        run_frame(mk_cmd(1'b0, 1, 2, 16'h0F0F), 16'h0, 1'b0);
        wr(2'd0, mk_cmd(1'b0, 2, 3, 16'h00FF));
        while (busy) @(negedge clk);
        @(negedge clk);
        wr(2'd1, 32'hFFFF_FFFE);
        @(negedge clk);
        check(evt == 1'b1, "R8 zero write ignored", evt, 1);
        wr(2'd1, 32'h1);
        @(negedge clk);
        check(evt == 1'b0, "R8 cleared after ignore", evt, 0);

        // R8: clear lands on the completion edge (128*2 cycles after accept)
        set_speed(2, 0);
        wr(2'd0, mk_cmd(1'b0, 4, 4, 16'h1357));
        repeat (255) @(negedge clk);
        check(busy == 1'b1, "R6 busy before last edge", busy, 1);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'h0;
        check(busy == 1'b0, "R6 end edge", busy, 0);
        check(evt == 1'b1, "R8 set beats clear", evt, 1);
        wr(2'd1, 32'h1);
        @(negedge clk);
        check(evt == 1'b0, "R8 clear after tie", evt, 0);

        summary();
    end

endmodule